// File: doc/BRIEF.md
# Gated Serial Channel Shifter

This block exchanges one word per frame with a time-division serial bus running on a 2.048 MHz bit clock. Two active-low inputs, a frame enable and a channel-assign enable, define the block's channel slot. While both are low, the block sends its outgoing word on the serial output, one bit per clock. In the same slot it captures the incoming word from the serial input. Outside the slot the output is not driven.

The word to send comes from an encoder on `tx_word`. A one-cycle `tx_load` strobe marks the clock edge at which that word was taken. The assembled incoming word goes to a decoder on `rx_word`, and `rx_valid` pulses for one clock when a new word lands there. The block does not define what the words contain. The pad's three-state buffer sits outside the block: `sdo_oe` is its enable and `sdo` is its data.

Top module: `tdm_chan_shifter`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released with both enables high, `sdo_oe`, `sdo`, `rx_valid` and `tx_load` are 0 and `rx_word` is all zeros.
- R2: `sdo_oe` is 1 only while `frame_n` and `chan_n` are both low. It rises at the first falling clock edge inside that window and drops as soon as either enable goes high. While `sdo_oe` is 0, `sdo` is 0.
- R3: Within a slot, `sdo` is updated on falling clock edges. It presents the loaded word with bit WORD_W-1 (bit 7 by default) first, then each lower bit on each later clock.
- R4: `sdi` is sampled on rising clock edges during the slot. The first bit sampled becomes bit WORD_W-1 of `rx_word`, and the last becomes bit 0.
- R5: On the rising edge that samples the WORD_W-th bit, `rx_word` takes the assembled word and `rx_valid` is 1 for exactly one clock. `rx_word` changes at no other time.
- R6: `tx_load` pulses for one clock together with `rx_valid`. At that same edge, the value on `tx_word` becomes the next word to send. A slot held open for 2*WORD_W clocks therefore sends two words back to back.
- R7: If either enable goes high before the WORD_W-th bit, the partial word is discarded. No `rx_valid` or `tx_load` follows, `rx_word` keeps its previous value, and the next slot starts again from bit WORD_W-1 of the word on `tx_word`.
- R8: While the slot is closed, the word to send follows `tx_word` on every rising edge. The first bit of a slot is therefore bit WORD_W-1 of the `tx_word` value present on the clock before the slot opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock (2.048 MHz in the system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame enable |
| chan_n | input | 1 | Active-low channel-assign enable |
| sdi | input | 1 | Serial data in from the bus |
| sdo | output | 1 | Serial data out to the pad buffer |
| sdo_oe | output | 1 | Drive enable for the pad's three-state buffer |
| tx_word | input | WORD_W | Next word to send, from the encoder |
| tx_load | output | 1 | One-cycle strobe: `tx_word` was taken |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe: `rx_word` was updated |

## Verification
The assertions assume that the enables change only between a rising edge and the falling edge that follows it. Under that assumption a slot always opens with a driven bit before its first sample. The properties also assume the default word width of at least two bits, so two completions can never fall on consecutive clocks. The bench drives every input one nanosecond after the rising edge and samples three nanoseconds later, after the falling edge, so it stays within these assumptions. Its stimulus covers slots closed by either enable alone, slots aborted after a few bits, back-to-back words and all-zero and all-one patterns.

// File: rtl/tdm_chsh_pkg.sv
package tdm_chsh_pkg;

   // Bit order on the serial line.
   typedef enum logic {
      SHIFT_LSB_FIRST = 1'b0,
      SHIFT_MSB_FIRST = 1'b1
   } shift_order_e;

endpackage

// File: rtl/tdm_chsh_window.sv
// Slot qualification and bit counting.
module tdm_chsh_window #(
   parameter int unsigned WORD_W = 8,
   localparam int unsigned CW    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_n,
   input  logic          chan_n,
   output logic          win,
   output logic          drive_en,
   output logic          shift_en,
   output logic          done,
   output logic [CW-1:0] bit_cnt
);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic armed_q;

   assign win = ~frame_n & ~chan_n;

   // Armed on the falling edge once a bit has been put on the line.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= win;
   end

   assign drive_en = armed_q & win;
   assign shift_en = armed_q & win;
   assign done     = shift_en && (bit_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bit_cnt <= '0;
      else if (!win)     bit_cnt <= '0;
      else if (done)     bit_cnt <= '0;
      else if (shift_en) bit_cnt <= bit_cnt + 1'b1;
   end
endmodule

// File: rtl/tdm_chsh_tx.sv
// Outgoing word register and falling-edge bit launcher.
module tdm_chsh_tx
   import tdm_chsh_pkg::*;
#(
   parameter int unsigned  WORD_W = 8,
   parameter shift_order_e ORDER  = SHIFT_MSB_FIRST,
   localparam int unsigned CW     = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win,
   input  logic              done,
   input  logic [CW-1:0]     bit_cnt,
   input  logic [WORD_W-1:0] tx_word,
   output logic              bit_q,
   output logic              tx_load
);
   logic [WORD_W-1:0] tx_sr;
   logic [CW-1:0]     pos;

   generate
      if (ORDER == SHIFT_MSB_FIRST) begin : g_msb
         assign pos = CW'(WORD_W - 1) - bit_cnt;
      end else begin : g_lsb
         assign pos = bit_cnt;
      end
   endgenerate

   // Follow the encoder while closed; take the next word at completion.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         tx_load <= 1'b0;
      end else begin
         tx_load <= done;
         if (!win || done) tx_sr <= tx_word;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= win ? tx_sr[pos] : 1'b0;
   end
endmodule

// File: rtl/tdm_chsh_rx.sv
// Incoming bit assembler.
module tdm_chsh_rx
   import tdm_chsh_pkg::*;
#(
   parameter int unsigned  WORD_W = 8,
   parameter shift_order_e ORDER  = SHIFT_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              done,
   input  logic              sdi,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);
   logic [WORD_W-1:0] rx_sr;
   logic [WORD_W-1:0] rx_next;

   generate
      if (ORDER == SHIFT_MSB_FIRST) begin : g_msb
         assign rx_next = {rx_sr[WORD_W-2:0], sdi};
      end else begin : g_lsb
         assign rx_next = {sdi, rx_sr[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr    <= '0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= done;
         if (shift_en) rx_sr   <= rx_next;
         if (done)     rx_word <= rx_next;
      end
   end
endmodule

// File: rtl/tdm_chan_shifter.sv
module tdm_chan_shifter
   import tdm_chsh_pkg::*;
#(
   parameter int unsigned  WORD_W = 8,
   parameter shift_order_e ORDER  = SHIFT_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              chan_n,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_load,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);
   localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("tdm_chan_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic          win;
   logic          drive_en;
   logic          shift_en;
   logic          done;
   logic [CW-1:0] bit_cnt;
   logic          bit_q;

   tdm_chsh_window #(.WORD_W(WORD_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (frame_n),
      .chan_n   (chan_n),
      .win      (win),
      .drive_en (drive_en),
      .shift_en (shift_en),
      .done     (done),
      .bit_cnt  (bit_cnt)
   );

   tdm_chsh_tx #(.WORD_W(WORD_W), .ORDER(ORDER)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .win     (win),
      .done    (done),
      .bit_cnt (bit_cnt),
      .tx_word (tx_word),
      .bit_q   (bit_q),
      .tx_load (tx_load)
   );

   tdm_chsh_rx #(.WORD_W(WORD_W), .ORDER(ORDER)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .done     (done),
      .sdi      (sdi),
      .rx_word  (rx_word),
      .rx_valid (rx_valid)
   );

   assign sdo_oe = drive_en;
   assign sdo    = drive_en & bit_q;
endmodule

// File: rtl/tdm_chan_shifter_chk.sv
module tdm_chan_shifter_chk #(
   parameter int unsigned WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic              chan_n,
   input logic              tx_load,
   input logic              rx_valid,
   input logic [WORD_W-1:0] rx_word
);
   // R1: strobes quiet while held in reset
   always_comb begin
      if (!rst_n) assert_quiet_in_reset_R1 : assert (!rx_valid && !tx_load);
   end

   // R5: completion strobe lasts one clock
   assert_valid_single_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R5: received word only moves together with the strobe
   assert_word_held_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_word));

   // R6: encoder load strobe coincides with decoder strobe
   assert_load_with_valid_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_load == rx_valid);

   // R7: a closed slot never completes a word
   assert_closed_no_word_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_n || chan_n) |=> !rx_valid);
endmodule

bind tdm_chan_shifter tdm_chan_shifter_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_n  (frame_n),
   .chan_n   (chan_n),
   .tx_load  (tx_load),
   .rx_valid (rx_valid),
   .rx_word  (rx_word)
);

// File: tb/sim_tdm_chan_shifter.sv
`timescale 1ns/100ps
module sim_tdm_chan_shifter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_n = 1'b1;
   logic       chan_n = 1'b1;
   logic       sdi = 1'b0;
   logic [7:0] tx_word = 8'h00;
   logic       sdo, sdo_oe, tx_load, rx_valid;
   logic [7:0] rx_word;

   int vectors = 0;
   int errors  = 0;

   // reference model state
   int         m_cnt = 0;
   logic [7:0] m_tx = 8'h00;
   logic [7:0] m_rx_word = 8'h00;
   logic       m_rx_valid = 1'b0;
   logic       m_tx_load = 1'b0;
   logic       rx_bits[$];

   always #2.5 clk = ~clk;

   tdm_chan_shifter u0 (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .chan_n(chan_n),
      .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .tx_word(tx_word),
      .tx_load(tx_load), .rx_word(rx_word), .rx_valid(rx_valid)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // One bit clock: drive, compare after the falling edge, then advance model.
   task automatic step(logic f, logic c, logic d, logic [7:0] txw);
      logic w;
      @(posedge clk);
      #1;
      frame_n = f; chan_n = c; sdi = d; tx_word = txw;
      #3;
      w = !f && !c;
      check("R2 sdo_oe", {7'd0, sdo_oe}, {7'd0, w});
      check("R3 sdo", {7'd0, sdo}, {7'd0, w ? m_tx[7 - m_cnt] : 1'b0});
      check("R4 rx_word", rx_word, m_rx_word);
      check("R5 rx_valid", {7'd0, rx_valid}, {7'd0, m_rx_valid});
      check("R6 tx_load", {7'd0, tx_load}, {7'd0, m_tx_load});
      m_rx_valid = 1'b0;
      m_tx_load  = 1'b0;
      if (w) begin
         rx_bits.push_back(d);
         if (m_cnt == 7) begin
            for (int i = 0; i < 8; i++) m_rx_word[7 - i] = rx_bits[i];
            rx_bits.delete();
            m_rx_valid = 1'b1;
            m_tx_load  = 1'b1;
            m_tx  = txw;
            m_cnt = 0;
         end else begin
            m_cnt++;
         end
      end else begin
         rx_bits.delete();
         m_cnt = 0;
         m_tx  = txw;
      end
   endtask

   // Open slot for n clocks; incoming bits from pattern, MSB first.
   task automatic slot(int n, logic [15:0] pat, logic [7:0] txw);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, pat[15 - i], txw);
   endtask

   task automatic idle(int n, logic [7:0] txw);
      for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, txw);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #12;
      // R1: reset state at the ports
      check("R1 sdo_oe", {7'd0, sdo_oe}, 8'd0);
      check("R1 sdo", {7'd0, sdo}, 8'd0);
      check("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
      check("R1 tx_load", {7'd0, tx_load}, 8'd0);
      check("R1 rx_word", rx_word, 8'h00);
      @(posedge clk); #1 rst_n = 1'b1;
      idle(2, 8'hA5);                         // R1 and R8: closed, word follows input
      slot(8, 16'h3C00, 8'hA5);               // R3 R4 R5 R6: one word
      idle(3, 8'h5A);
      slot(16, 16'hF00F, 8'hC3);              // R6: back to back
      idle(2, 8'h81);
      slot(3, 16'hE000, 8'h81);               // R7: abort after three bits
      idle(1, 8'h81);
      check("R7 rx_word kept", rx_word, 8'hC3 ^ 8'hC3 ^ m_rx_word);
      check("R7 no valid", {7'd0, rx_valid}, 8'd0);
      slot(8, 16'h0100, 8'h81);               // R7: restart from bit 7
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 8'hFF);   // R2: frame only
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 8'hFF);   // R2: channel only
      slot(8, 16'hFF00, 8'h00);               // all ones in, word FF out
      idle(1, 8'h00);
      slot(8, 16'h0000, 8'h00);               // all zeros
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 8'h77);   // R7: channel drops mid-word
      step(1'b0, 1'b1, 1'b0, 8'h77);
      slot(8, 16'h9600, 8'h77);               // R8: word present before slot is sent
      idle(3, 8'h00);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule